// File: doc/BRIEF.md
# Write-Back Set-Associative Cache Tag Engine

This block is one level of a set-associative cache that keeps tags, valid bits, dirty bits and replacement state, but no data. A CPU-side request names an operation (read, write or invalidate) and a byte address. The block looks the address up and returns a single-cycle response whose hit flag says whether the block was resident. On a miss it picks a victim way. If that victim is dirty, it first pushes the victim's block address out on a writeback channel. It then asks for the new block on a fill channel and installs the tag once the fill is acknowledged.

Writes use write-back and write-allocate: they only mark the block dirty. Traffic to the memory side happens only when a dirty block is evicted or invalidated. The replacement policy is chosen at run time among first-in-first-out, least-recently-used and most-recently-used. Four event counters record hits, misses, evictions and dirty writebacks. The memory-side channels carry block-aligned addresses, so they can drive the request side of another instance.

Top module: `wbc_cache`

## Requirements
- R1: The set count is CACHE_BYTES / (BLOCK_BYTES × WAYS). Two addresses that differ only in their offset bits (the low log2(BLOCK_BYTES) bits) map to the same block, so after the block has been filled, an access at any offset within it is a hit.
- R2: A read miss raises one fill request. Its address is the request address with the offset bits cleared. After the fill is acknowledged, the response has hit=0, and a later read of the same block responds with hit=1.
- R3: A write hit sets the block's dirty bit and raises no writeback or fill request.
- R4: A write miss allocates the block through a fill and leaves it dirty, so its later eviction produces a writeback.
- R5: While a set has invalid ways, a miss fills the lowest-indexed invalid way and evicts nothing, so the eviction counter does not change.
- R6: With policy code 0 (FIFO), the victim is the valid way filled earliest. Hits do not change this order.
- R7: With policy code 1 (LRU; code 3 behaves the same), the victim is the least recently filled-or-hit way.
- R8: With policy code 2 (MRU), the victim is the most recently filled-or-hit way.
- R9: Evicting a clean block increments only the eviction counter and raises no writeback.
- R10: Evicting a dirty block increments both the eviction and writeback counters. It raises a writeback carrying the victim's block address, and that writeback completes before the fill request is raised.
- R11: An invalidate (operation code 2) of a resident block responds with hit=1 and clears the block. If the block is dirty, a writeback of it completes first and the writeback counter increments. An invalidate of an absent block responds with hit=0 and changes nothing. Operation codes: 0 read, 1 write, 2 invalidate.
- R12: Each read or write increments exactly one of the hit and miss counters. Invalidates increment neither. All counters are zero after reset.
- R13: req_ready is high only while the block is idle. A request raised with wb_valid or fill_valid keeps its address stable until it is acknowledged. rsp_valid is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy | input | 2 | Replacement policy: 0 FIFO, 1 LRU, 2 MRU |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_op | input | 2 | 0 read, 1 write, 2 invalidate |
| req_addr | input | ADDR_W | Byte address |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Block was resident |
| wb_valid | output | 1 | Writeback request |
| wb_ready | input | 1 | Writeback accepted |
| wb_addr | output | ADDR_W | Block address being written back |
| fill_valid | output | 1 | Fill request |
| fill_ready | input | 1 | Fill delivered |
| fill_addr | output | ADDR_W | Block address to fetch |
| cnt_hit | output | CNT_W | Hit count |
| cnt_miss | output | CNT_W | Miss count |
| cnt_evict | output | CNT_W | Valid-victim eviction count |
| cnt_wb | output | CNT_W | Dirty writeback count |

## Verification
The bench builds the default geometry: 256 bytes, 16-byte blocks, four ways and 16-bit addresses, which gives four sets with ten tag bits. Random addresses draw from only six tags per set, so every set fills, evicts and refills many times. The random traffic also switches the policy between accesses, mixes writes and invalidates, and stalls both memory channels for random numbers of cycles. Under this load the dirty-victim writeback ordering, the victim choice after a policy switch, and invalid-way reuse after an invalidate are all exercised.

// File: rtl/wbc_pkg.sv
// Shared encodings for the write-back cache tag engine.
// Assumes: request and policy codes are 2 bits wide on the ports.
package wbc_pkg;
    localparam logic [1:0] OP_READ  = 2'd0;
    localparam logic [1:0] OP_WRITE = 2'd1;
    localparam logic [1:0] OP_INVAL = 2'd2;

    localparam logic [1:0] POL_FIFO = 2'd0;
    localparam logic [1:0] POL_LRU  = 2'd1;
    localparam logic [1:0] POL_MRU  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WB,
        ST_FILL
    } state_e;
endpackage

// File: rtl/wbc_rank_touch.sv
// Moves one way to rank 0 (newest) in a per-set rank permutation.
// Ways that were newer than it age by one; older ways keep their rank.
// Assumes: ranks_i holds a permutation of 0..WAYS-1.
module wbc_rank_touch #(
    parameter int WAYS   = 4,
    parameter int RANK_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][RANK_W-1:0] ranks_i,
    input  logic [RANK_W-1:0]           way_i,
    output logic [WAYS-1:0][RANK_W-1:0] ranks_o
);
    logic [RANK_W-1:0] pivot;

    // Reorder ranks around the touched way.
    always_comb begin
        pivot = ranks_i[way_i];
        for (int w = 0; w < WAYS; w++) begin
            if (RANK_W'(w) == way_i)
                ranks_o[w] = '0;
            else if (ranks_i[w] < pivot)
                ranks_o[w] = ranks_i[w] + RANK_W'(1);
            else
                ranks_o[w] = ranks_i[w];
        end
    end
endmodule

// File: rtl/wbc_victim_pick.sv
// Chooses the way to replace within one set.
// The lowest-indexed invalid way wins. Otherwise the policy decides:
// FIFO takes the oldest fill rank, LRU the oldest use rank, and MRU
// use rank 0. Assumes both rank vectors are permutations.
module wbc_victim_pick
    import wbc_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int RANK_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             valid_i,
    input  logic [WAYS-1:0][RANK_W-1:0] use_rank_i,
    input  logic [WAYS-1:0][RANK_W-1:0] fill_rank_i,
    input  logic [1:0]                  policy_i,
    output logic [RANK_W-1:0]           victim_o
);
    localparam logic [RANK_W-1:0] OLDEST = RANK_W'(WAYS - 1);

    logic found;

    // Priority search: free ways first, then the policy target.
    always_comb begin
        victim_o = '0;
        found    = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid_i[w]) begin
                victim_o = RANK_W'(w);
                found    = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                case (policy_i)
                    POL_FIFO: if (fill_rank_i[w] == OLDEST) victim_o = RANK_W'(w);
                    POL_MRU:  if (use_rank_i[w] == '0)      victim_o = RANK_W'(w);
                    default:  if (use_rank_i[w] == OLDEST)  victim_o = RANK_W'(w);
                endcase
            end
        end
    end
endmodule

// File: rtl/wbc_event_counters.sv
// Four free-running event counters, each advancing by one on its pulse.
// Index order: 0 hit, 1 miss, 2 eviction, 3 writeback. Counters wrap.
module wbc_event_counters #(
    parameter int CNT_W = 16,
    parameter int NUM   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            inc_i,
    output logic [NUM-1:0][CNT_W-1:0] cnt_o
);
    for (genvar g = 0; g < NUM; g++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;

        // Count one event per asserted cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)        cnt_q <= '0;
            else if (inc_i[g]) cnt_q <= cnt_q + CNT_W'(1);
        end

        assign cnt_o[g] = cnt_q;
    end
endmodule

// File: rtl/wbc_cache.sv
// Tag-only write-back, write-allocate set-associative cache level.
// Handles one request at a time: IDLE accepts, LOOK resolves hit or
// victim, WB pushes a dirty block out, and FILL fetches the new block.
// Assumes: SETS and WAYS are powers of two, SETS >= 2 and WAYS >= 2,
// and the policy input is steady while a request is in flight.
module wbc_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int CACHE_BYTES = 256,
    parameter int BLOCK_BYTES = 16,
    parameter int WAYS        = 4,
    parameter int CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        policy,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              fill_valid,
    input  logic              fill_ready,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_evict,
    output logic [CNT_W-1:0]  cnt_wb
);
    localparam int SETS   = CACHE_BYTES / (BLOCK_BYTES * WAYS);
    localparam int OFF_W  = $clog2(BLOCK_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int RANK_W = $clog2(WAYS);
    localparam int BLK_W  = ADDR_W - OFF_W;

    state_e            state_q;
    logic [1:0]        op_q;
    logic [BLK_W-1:0]  blk_q;
    logic [RANK_W-1:0] cur_way_q;
    logic [TAG_W-1:0]  wb_tag_q;
    logic              rsp_valid_q, rsp_hit_q;

    logic [TAG_W-1:0]             tag_q       [SETS][WAYS];
    logic [WAYS-1:0]              valid_q     [SETS];
    logic [WAYS-1:0]              dirty_q     [SETS];
    logic [WAYS-1:0][RANK_W-1:0]  use_rank_q  [SETS];
    logic [WAYS-1:0][RANK_W-1:0]  fill_rank_q [SETS];

    logic [IDX_W-1:0]             idx;
    logic [TAG_W-1:0]             req_tag;
    logic [WAYS-1:0]              hit_vec;
    logic                         hit_any;
    logic [RANK_W-1:0]            hit_way, victim, touch_way;
    logic [WAYS-1:0][RANK_W-1:0]  use_next, fill_next;
    logic                         is_rw, victim_valid, victim_dirty;
    logic [3:0]                   inc;
    logic [3:0][CNT_W-1:0]        cnt;
    logic                         unused_off;

    assign unused_off = ^req_addr[OFF_W-1:0];
    assign idx        = blk_q[IDX_W-1:0];
    assign req_tag    = blk_q[BLK_W-1:IDX_W];
    assign is_rw      = (op_q != OP_INVAL);

    // Compare the request tag against every way of the selected set.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = valid_q[idx][w] && (tag_q[idx][w] == req_tag);
            if (hit_vec[w]) hit_way = RANK_W'(w);
        end
        hit_any = |hit_vec;
    end

    wbc_victim_pick #(.WAYS(WAYS), .RANK_W(RANK_W)) u_pick (
        .valid_i     (valid_q[idx]),
        .use_rank_i  (use_rank_q[idx]),
        .fill_rank_i (fill_rank_q[idx]),
        .policy_i    (policy),
        .victim_o    (victim)
    );

    assign victim_valid = valid_q[idx][victim];
    assign victim_dirty = dirty_q[idx][victim];
    assign touch_way    = (state_q == ST_LOOK) ? hit_way : cur_way_q;

    wbc_rank_touch #(.WAYS(WAYS), .RANK_W(RANK_W)) u_use_touch (
        .ranks_i (use_rank_q[idx]),
        .way_i   (touch_way),
        .ranks_o (use_next)
    );

    wbc_rank_touch #(.WAYS(WAYS), .RANK_W(RANK_W)) u_fill_touch (
        .ranks_i (fill_rank_q[idx]),
        .way_i   (touch_way),
        .ranks_o (fill_next)
    );

    // Event pulses, all raised during the lookup cycle.
    always_comb begin
        inc    = '0;
        inc[0] = (state_q == ST_LOOK) && is_rw && hit_any;
        inc[1] = (state_q == ST_LOOK) && is_rw && !hit_any;
        inc[2] = inc[1] && victim_valid;
        inc[3] = (inc[2] && victim_dirty) ||
                 ((state_q == ST_LOOK) && !is_rw && hit_any && dirty_q[idx][hit_way]);
    end

    wbc_event_counters #(.CNT_W(CNT_W), .NUM(4)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (inc),
        .cnt_o (cnt)
    );

    // Control sequence plus tag, state-bit and rank storage updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            op_q        <= OP_READ;
            blk_q       <= '0;
            cur_way_q   <= '0;
            wb_tag_q    <= '0;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]       <= '0;
                    use_rank_q[s][w]  <= RANK_W'(w);
                    fill_rank_q[s][w] <= RANK_W'(w);
                end
            end
        end else begin
            rsp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q    <= req_op;
                        blk_q   <= req_addr[ADDR_W-1:OFF_W];
                        state_q <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (!is_rw) begin
                        cur_way_q <= hit_way;
                        wb_tag_q  <= req_tag;
                        if (hit_any && dirty_q[idx][hit_way]) begin
                            state_q <= ST_WB;
                        end else begin
                            if (hit_any) valid_q[idx][hit_way] <= 1'b0;
                            rsp_valid_q <= 1'b1;
                            rsp_hit_q   <= hit_any;
                            state_q     <= ST_IDLE;
                        end
                    end else if (hit_any) begin
                        if (op_q == OP_WRITE) dirty_q[idx][hit_way] <= 1'b1;
                        use_rank_q[idx] <= use_next;
                        rsp_valid_q     <= 1'b1;
                        rsp_hit_q       <= 1'b1;
                        state_q         <= ST_IDLE;
                    end else begin
                        cur_way_q <= victim;
                        wb_tag_q  <= tag_q[idx][victim];
                        state_q   <= (victim_valid && victim_dirty) ? ST_WB : ST_FILL;
                    end
                end
                ST_WB: begin
                    if (wb_ready) begin
                        valid_q[idx][cur_way_q] <= 1'b0;
                        dirty_q[idx][cur_way_q] <= 1'b0;
                        if (!is_rw) begin
                            rsp_valid_q <= 1'b1;
                            rsp_hit_q   <= 1'b1;
                            state_q     <= ST_IDLE;
                        end else begin
                            state_q <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (fill_ready) begin
                        tag_q[idx][cur_way_q]   <= req_tag;
                        valid_q[idx][cur_way_q] <= 1'b1;
                        dirty_q[idx][cur_way_q] <= (op_q == OP_WRITE);
                        use_rank_q[idx]         <= use_next;
                        fill_rank_q[idx]        <= fill_next;
                        rsp_valid_q             <= 1'b1;
                        rsp_hit_q               <= 1'b0;
                        state_q                 <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign rsp_valid  = rsp_valid_q;
    assign rsp_hit    = rsp_hit_q;
    assign wb_valid   = (state_q == ST_WB);
    assign wb_addr    = {wb_tag_q, idx, {OFF_W{1'b0}}};
    assign fill_valid = (state_q == ST_FILL);
    assign fill_addr  = {req_tag, idx, {OFF_W{1'b0}}};
    assign cnt_hit    = cnt[0];
    assign cnt_miss   = cnt[1];
    assign cnt_evict  = cnt[2];
    assign cnt_wb     = cnt[3];
endmodule

// File: rtl/wbc_cache_chk.sv
// Port-level protocol and counter checks for wbc_cache, bound below.
module wbc_cache_chk #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              fill_valid,
    input logic              fill_ready,
    input logic [ADDR_W-1:0] fill_addr,
    input logic [CNT_W-1:0]  cnt_hit,
    input logic [CNT_W-1:0]  cnt_miss,
    input logic [CNT_W-1:0]  cnt_evict,
    input logic [CNT_W-1:0]  cnt_wb
);
    // R13: an unacknowledged writeback holds its address.
    a_r13_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));

    // R13: an unacknowledged fill holds its address.
    a_r13_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && !fill_ready |=> fill_valid && $stable(fill_addr));

    // R13: no memory traffic while idle.
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !wb_valid && !fill_valid);

    // R13: the response is a single-cycle pulse.
    a_r13_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: the fill never overlaps the writeback that must precede it.
    a_r10_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> !fill_valid);

    // R12: hit and miss counters step by at most one, never together.
    a_r12_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(cnt_hit - $past(cnt_hit)) <= CNT_W'(1));
    a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !((cnt_hit != $past(cnt_hit)) && (cnt_miss != $past(cnt_miss))));

    // R9: an eviction only ever comes with a miss.
    a_r9_evict_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_evict != $past(cnt_evict)) |-> (cnt_miss != $past(cnt_miss)));

    // R10: a writeback counted on a miss implies an eviction counted.
    a_r10_wb_with_evict: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wb != $past(cnt_wb)) && (cnt_miss != $past(cnt_miss))
            |-> (cnt_evict != $past(cnt_evict)));
endmodule

bind wbc_cache wbc_cache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_wbc_cache_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .wb_valid   (wb_valid),
    .wb_ready   (wb_ready),
    .wb_addr    (wb_addr),
    .fill_valid (fill_valid),
    .fill_ready (fill_ready),
    .fill_addr  (fill_addr),
    .cnt_hit    (cnt_hit),
    .cnt_miss   (cnt_miss),
    .cnt_evict  (cnt_evict),
    .cnt_wb     (cnt_wb)
);

// File: tb/wbc_cache_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a timestamp-based reference model in bench
// functions, directed corner cases, then seeded random traffic.
module wbc_cache_bench;
    localparam int ADDR_W = 16, CACHE_BYTES = 256, BLOCK_BYTES = 16, WAYS = 4, CNT_W = 16;
    localparam int SETS  = CACHE_BYTES / (BLOCK_BYTES * WAYS);
    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int IDX_W = $clog2(SETS);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] policy = 2'd0, req_op = 2'd0;
    logic req_valid = 1'b0, wb_ready = 1'b0, fill_ready = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready, rsp_valid, rsp_hit, wb_valid, fill_valid;
    logic [ADDR_W-1:0] wb_addr, fill_addr;
    logic [CNT_W-1:0] cnt_hit, cnt_miss, cnt_evict, cnt_wb;

    always #10 clk = ~clk;

    wbc_cache #(.ADDR_W(ADDR_W), .CACHE_BYTES(CACHE_BYTES), .BLOCK_BYTES(BLOCK_BYTES),
                .WAYS(WAYS), .CNT_W(CNT_W)) u_wbc_cache (
        .clk(clk), .rst_n(rst_n), .policy(policy),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
        .cnt_hit(cnt_hit), .cnt_miss(cnt_miss), .cnt_evict(cnt_evict), .cnt_wb(cnt_wb));

    int n_tests = 0, n_fail = 0;

    // Reference model state.
    int  m_tag [SETS][WAYS];
    bit  m_val [SETS][WAYS];
    bit  m_dty [SETS][WAYS];
    int  m_fill_t [SETS][WAYS];
    int  m_use_t  [SETS][WAYS];
    int  stamp;
    int  e_hit, e_miss, e_evict, e_wb;
    bit  x_hit, x_wb, x_fill;
    int  x_wb_addr, x_fill_addr;

    // Observed results of the last access.
    bit  o_hit;
    int  o_wb_n, o_fill_n, o_wb_addr, o_fill_addr;

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int blk(int tag, int set);
        return (tag << (OFF_W + IDX_W)) | (set << OFF_W);
    endfunction

    function automatic int pick_victim(int s, logic [1:0] pol);
        int v = -1;
        for (int w = 0; w < WAYS; w++) if (v < 0 && !m_val[s][w]) v = w;
        if (v >= 0) return v;
        v = 0;
        for (int w = 1; w < WAYS; w++) begin
            if (pol == 2'd0 && m_fill_t[s][w] < m_fill_t[s][v]) v = w;
            else if (pol == 2'd2 && m_use_t[s][w] > m_use_t[s][v]) v = w;
            else if ((pol == 2'd1 || pol == 2'd3) && m_use_t[s][w] < m_use_t[s][v]) v = w;
        end
        return v;
    endfunction

    task automatic model_access(logic [1:0] op, int addr);
        int s = (addr >> OFF_W) % SETS;
        int t = addr >> (OFF_W + IDX_W);
        int hw = -1;
        x_wb = 0; x_fill = 0; x_hit = 0;
        for (int w = 0; w < WAYS; w++) if (m_val[s][w] && m_tag[s][w] == t) hw = w;
        if (op == 2'd2) begin
            if (hw >= 0) begin
                x_hit = 1;
                if (m_dty[s][hw]) begin x_wb = 1; x_wb_addr = blk(t, s); e_wb++; end
                m_val[s][hw] = 0; m_dty[s][hw] = 0;
            end
        end else if (hw >= 0) begin
            x_hit = 1; e_hit++;
            if (op == 2'd1) m_dty[s][hw] = 1;
            m_use_t[s][hw] = ++stamp;
        end else begin
            int v = pick_victim(s, policy);
            e_miss++;
            if (m_val[s][v]) begin
                e_evict++;
                if (m_dty[s][v]) begin e_wb++; x_wb = 1; x_wb_addr = blk(m_tag[s][v], s); end
            end
            x_fill = 1; x_fill_addr = blk(t, s);
            m_tag[s][v] = t; m_val[s][v] = 1; m_dty[s][v] = (op == 2'd1);
            stamp++; m_fill_t[s][v] = stamp; m_use_t[s][v] = stamp;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        stamp = 0; e_hit = 0; e_miss = 0; e_evict = 0; e_wb = 0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_val[s][w] = 0; m_dty[s][w] = 0; m_tag[s][w] = 0;
                m_fill_t[s][w] = 0; m_use_t[s][w] = 0;
            end
    endtask

    // Drive one request, serve memory with random stalls, compare to model.
    task automatic do_access(logic [1:0] op, int addr);
        int guard = 0;
        bit done = 0, order_bad = 0;
        int cap_wb = 0, cap_fill = 0;
        model_access(op, addr);
        o_wb_n = 0; o_fill_n = 0; o_hit = 0;
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = ADDR_W'(addr);
        @(negedge clk);
        req_valid = 0;
        chk("R13", "req_ready while busy", int'(req_ready), 0);
        while (!done && guard < 1000) begin
            guard++;
            if (wb_ready)   begin o_wb_n++; o_wb_addr = cap_wb; if (o_fill_n > 0) order_bad = 1; end
            if (fill_ready) begin o_fill_n++; o_fill_addr = cap_fill; end
            wb_ready = 0; fill_ready = 0;
            if (rsp_valid) begin
                done = 1; o_hit = rsp_hit;
            end else begin
                if (wb_valid && ($urandom % 3 != 0))   begin wb_ready = 1;   cap_wb = int'(wb_addr); end
                if (fill_valid && ($urandom % 3 != 0)) begin fill_ready = 1; cap_fill = int'(fill_addr); end
                @(negedge clk);
            end
        end
        chk("R13", "response seen", int'(done), 1);
        chk(op == 2'd2 ? "R11" : (op == 2'd1 ? "R4" : "R2"), "hit flag", int'(o_hit), int'(x_hit));
        chk("R10", "writeback count", o_wb_n, int'(x_wb));
        if (x_wb && o_wb_n == 1) chk("R10", "writeback address", o_wb_addr, x_wb_addr);
        chk("R10", "writeback before fill", int'(order_bad), 0);
        chk("R2", "fill count", o_fill_n, int'(x_fill));
        if (x_fill && o_fill_n == 1) chk("R2", "fill address", o_fill_addr, x_fill_addr);
        chk("R12", "hit counter", int'(cnt_hit), e_hit);
        chk("R12", "miss counter", int'(cnt_miss), e_miss);
        chk("R9", "evict counter", int'(cnt_evict), e_evict);
        chk("R10", "writeback counter", int'(cnt_wb), e_wb);
    endtask

    task automatic fill_four(int set);
        for (int t = 1; t <= 4; t++) do_access(2'd0, blk(t, set));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R12 / R13: reset state.
        chk("R12", "counters after reset", int'(cnt_hit | cnt_miss | cnt_evict | cnt_wb), 0);
        chk("R13", "ready after reset", int'(req_ready), 1);
        chk("R13", "memory idle after reset", int'(wb_valid | fill_valid | rsp_valid), 0);

        // R1 / R2: offsets within one block.
        policy = 2'd0;
        do_access(2'd0, 16'h0103);
        chk("R2", "first read misses", int'(o_hit), 0);
        chk("R2", "fill aligned", o_fill_addr, 16'h0100);
        do_access(2'd0, 16'h010C);
        chk("R1", "other offset hits", int'(o_hit), 1);
        do_access(2'd0, 16'h0100);
        chk("R2", "re-read hits", int'(o_hit), 1);

        // R5 / R6: free ways used first, then FIFO ignores hits.
        do_reset(); policy = 2'd0;
        fill_four(0);
        chk("R5", "no eviction while ways free", int'(cnt_evict), 0);
        for (int t = 1; t <= 4; t++) begin
            do_access(2'd0, blk(t, 0));
            chk("R5", "all four ways resident", int'(o_hit), 1);
        end
        do_access(2'd0, blk(5, 0));
        do_access(2'd0, blk(1, 0));
        chk("R6", "FIFO evicted oldest fill", int'(o_hit), 0);

        // R7: LRU.
        do_reset(); policy = 2'd1;
        fill_four(0);
        do_access(2'd0, blk(1, 0));
        do_access(2'd0, blk(5, 0));
        do_access(2'd0, blk(1, 0));
        chk("R7", "LRU kept recently hit block", int'(o_hit), 1);
        do_access(2'd0, blk(2, 0));
        chk("R7", "LRU evicted least recent", int'(o_hit), 0);

        // R8: MRU.
        do_reset(); policy = 2'd2;
        fill_four(0);
        do_access(2'd0, blk(1, 0));
        do_access(2'd0, blk(5, 0));
        do_access(2'd0, blk(2, 0));
        chk("R8", "MRU kept older block", int'(o_hit), 1);
        do_access(2'd0, blk(1, 0));
        chk("R8", "MRU evicted most recent", int'(o_hit), 0);

        // R3 / R4 / R9 / R10: write allocate, dirty and clean victims.
        do_reset(); policy = 2'd0;
        do_access(2'd1, blk(1, 1));
        chk("R4", "write miss allocates", o_fill_n, 1);
        do_access(2'd1, blk(1, 1) + 4);
        chk("R3", "write hit makes no traffic", o_wb_n + o_fill_n, 0);
        for (int t = 2; t <= 4; t++) do_access(2'd0, blk(t, 1));
        do_access(2'd0, blk(5, 1));
        chk("R10", "dirty victim written back", o_wb_n, 1);
        chk("R10", "victim block address", o_wb_addr, blk(1, 1));
        chk("R10", "eviction and writeback counted", int'(cnt_evict) * 16 + int'(cnt_wb), 16 + 1);
        do_access(2'd0, blk(6, 1));
        chk("R9", "clean victim no writeback", o_wb_n, 0);
        chk("R9", "clean victim counters", int'(cnt_evict) * 16 + int'(cnt_wb), 32 + 1);

        // R11: invalidate.
        do_access(2'd1, blk(7, 2));
        do_access(2'd2, blk(7, 2));
        chk("R11", "invalidate hit", int'(o_hit), 1);
        chk("R11", "dirty invalidate writeback", o_wb_addr, blk(7, 2));
        do_access(2'd0, blk(7, 2));
        chk("R11", "block gone after invalidate", int'(o_hit), 0);
        do_access(2'd2, blk(8, 2));
        chk("R11", "absent invalidate", int'(o_hit) + o_wb_n, 0);

        // Random traffic with policy switches.
        do_reset();
        for (int i = 0; i < 600; i++) begin
            logic [1:0] op;
            if (i % 40 == 0) policy = 2'($urandom % 4);
            op = ($urandom % 8 == 0) ? 2'd2 : 2'($urandom % 2);
            do_access(op, blk(int'($urandom % 6), int'($urandom % SETS)) + int'($urandom % BLOCK_BYTES));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule